// File: doc/BRIEF.md
# Heat-Weighted Transition Layer Picker

This block chooses the intermediate layer through which a packet travels when it must descend in a vertically stacked mesh. The request carries a source layer and a destination layer below it. Every layer from the destination up to and including the source is a candidate. The block returns one candidate, drawn at random with weights that fall in a straight line with height: the layer nearest the heat sink is the most likely and the source layer is the least likely. The aim is to steer cross-layer traffic towards the cooler bottom of the stack without piling all of it onto one layer.

The random source is a free-running 16-bit maximal-length linear feedback shift register. At the accepting edge, its state is scaled into the range [0, total weight) by a fixed-point multiply. The scaled value is then compared against the running sums of the triangular weights. The request uses a valid/ready handshake and so does the response. The response is registered and appears one cycle after acceptance.

Top module: `tls_layer_pick`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rsp_valid_o is 0 and req_ready_o is 1.
- R2: A request accepted on a clock edge (req_valid_i and req_ready_o both 1) produces rsp_valid_o = 1 immediately after that edge. With no new acceptance, rsp_valid_o returns to 0 after the edge on which rsp_ready_i is 1.
- R3: When req_src_i > req_dst_i, the returned layer lies in the inclusive range [req_dst_i, req_src_i].
- R4: When req_src_i <= req_dst_i, the returned layer equals req_dst_i.
- R5: While rsp_valid_o = 1 and rsp_ready_i = 0, req_ready_o is 0 and rsp_layer_o holds its value. A request presented during the stall is taken on the edge on which rsp_ready_i returns to 1.
- R6: With n = src - dst + 1 candidates, the candidate at offset j (j = 0 is the destination) has weight n - j, and the total T is n(n+1)/2. The 16-bit state L of the register at the accepting edge is never zero and visits all 65535 nonzero values once per 65535 cycles. The block forms r = floor(L*T / 65536) and returns dst + j for the smallest j whose cumulative weight (the sum of the weights at offsets 0..j) exceeds r. Over 65535 back-to-back acceptances, the count of each layer is therefore exactly the number of nonzero L that map to it.
- R7: Over a full period of back-to-back draws, each candidate is returned strictly more often than the candidate one layer above it. For four candidates, the frequencies are close to 4/10, 3/10, 2/10 and 1/10 from the bottom up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request this cycle |
| req_src_i | input | LAYER_W | Source layer of the packet |
| req_dst_i | input | LAYER_W | Destination layer of the packet |
| rsp_valid_o | output | 1 | Chosen layer is available |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_layer_o | output | LAYER_W | Chosen transition layer |

## Verification
Every result is due exactly one clock edge after the edge that accepts the request. The bench drives inputs on falling edges and reads the response on the next falling edge, so every sample falls half a period after the register updates. In the stall case, the held response is read on each falling edge while rsp_ready_i is low. The queued request's result is expected on the falling edge that follows the rising edge on which rsp_ready_i goes high. In the streaming runs, the request is held valid for 65535 consecutive edges and exactly one response is counted per falling edge. The response seen on falling edge k belongs to the acceptance on rising edge k.

// File: rtl/tls_pkg.sv
package tls_pkg;
  localparam int unsigned RNG_W = 16;
  localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;
  // taps for x^16 + x^14 + x^13 + x^11 + 1
  localparam logic [RNG_W-1:0] RNG_TAPS = 16'b1011_0100_0000_0000;

  function automatic int unsigned tri_sum(input int unsigned k);
    return (k * (k + 1)) / 2;
  endfunction
endpackage

// File: rtl/tls_lfsr.sv
module tls_lfsr
  import tls_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [RNG_W-1:0] state_o
);
  logic [RNG_W-1:0] q;
  logic             fb;

  assign fb = ^(q & RNG_TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RNG_SEED;
    else         q <= {q[RNG_W-2:0], fb};
  end

  assign state_o = q;
endmodule

// File: rtl/tls_scale.sv
module tls_scale
  import tls_pkg::*;
#(
  parameter int unsigned LAYER_W = 3,
  localparam int unsigned N_W   = LAYER_W + 1,
  localparam int unsigned MAX_N = 1 << LAYER_W,
  localparam int unsigned TOT_W = $clog2(tri_sum(MAX_N) + 1)
) (
  input  logic [LAYER_W-1:0] src_i,
  input  logic [LAYER_W-1:0] dst_i,
  input  logic [RNG_W-1:0]   rnd_i,
  output logic [N_W-1:0]     n_o,
  output logic [TOT_W-1:0]   r_o
);
  logic [N_W-1:0]         n;
  logic [2*N_W-1:0]       sq;
  logic [TOT_W-1:0]       total;
  logic [RNG_W+TOT_W-1:0] prod;

  // a request that does not descend degenerates to a single candidate
  assign n     = (src_i > dst_i) ? ({1'b0, src_i} - {1'b0, dst_i} + N_W'(1)) : N_W'(1);
  assign sq    = {{N_W{1'b0}}, n} * {{N_W{1'b0}}, n + N_W'(1)};
  assign total = TOT_W'(sq >> 1);
  assign prod  = {{TOT_W{1'b0}}, rnd_i} * {{RNG_W{1'b0}}, total};

  assign n_o = n;
  assign r_o = prod[RNG_W +: TOT_W];
endmodule

// File: rtl/tls_pick.sv
module tls_pick
  import tls_pkg::*;
#(
  parameter int unsigned LAYER_W = 3,
  localparam int unsigned N_W   = LAYER_W + 1,
  localparam int unsigned MAX_N = 1 << LAYER_W,
  localparam int unsigned TOT_W = $clog2(tri_sum(MAX_N) + 1),
  localparam int unsigned CUM_W = TOT_W + N_W
) (
  input  logic [N_W-1:0]     n_i,
  input  logic [TOT_W-1:0]   r_i,
  output logic [LAYER_W-1:0] off_o
);
  logic [MAX_N-1:0] hit;
  logic [CUM_W-1:0] n_ext;
  logic [CUM_W-1:0] r_ext;

  assign n_ext = CUM_W'(n_i);
  assign r_ext = CUM_W'(r_i);

  // cumulative weight of the first k candidates: k*n - k(k-1)/2
  for (genvar k = 1; k <= MAX_N; k++) begin : g_cum
    logic [CUM_W-1:0] cum;
    assign cum        = CUM_W'(k) * n_ext - CUM_W'((k * (k - 1)) / 2);
    assign hit[k-1]   = (n_ext >= CUM_W'(k)) && (cum > r_ext);
  end

  always_comb begin
    off_o = '0;
    for (int j = MAX_N - 1; j >= 0; j--) begin
      if (hit[j]) off_o = LAYER_W'(j);
    end
  end
endmodule

// File: rtl/tls_layer_pick.sv
module tls_layer_pick
  import tls_pkg::*;
#(
  parameter int unsigned LAYER_W = 3,
  localparam int unsigned N_W   = LAYER_W + 1,
  localparam int unsigned MAX_N = 1 << LAYER_W,
  localparam int unsigned TOT_W = $clog2(tri_sum(MAX_N) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LAYER_W-1:0] req_src_i,
  input  logic [LAYER_W-1:0] req_dst_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [LAYER_W-1:0] rsp_layer_o
);
  logic [RNG_W-1:0]   rnd_q;
  logic [N_W-1:0]     n;
  logic [TOT_W-1:0]   r;
  logic [LAYER_W-1:0] off;
  logic               accept;
  logic               vld_q;
  logic [LAYER_W-1:0] layer_q;

  tls_lfsr u_rng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd_q)
  );

  tls_scale #(.LAYER_W(LAYER_W)) u_scale (
    .src_i (req_src_i),
    .dst_i (req_dst_i),
    .rnd_i (rnd_q),
    .n_o   (n),
    .r_o   (r)
  );

  tls_pick #(.LAYER_W(LAYER_W)) u_pick (
    .n_i   (n),
    .r_i   (r),
    .off_o (off)
  );

  assign req_ready_o = !vld_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      layer_q <= '0;
    end else if (accept) begin
      vld_q   <= 1'b1;
      layer_q <= req_dst_i + off;
    end else if (rsp_ready_i) begin
      vld_q   <= 1'b0;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_layer_o = layer_q;
endmodule

// File: rtl/tls_layer_pick_chk.sv
module tls_layer_pick_chk
  import tls_pkg::*;
#(
  parameter int unsigned LAYER_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [LAYER_W-1:0] req_src_i,
  input logic [LAYER_W-1:0] req_dst_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [LAYER_W-1:0] rsp_layer_o,
  input logic [RNG_W-1:0]   rnd_i
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_RSP_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o) else $error("rsp missing");  // R2

  AST_RSP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && rsp_ready_i) |=> !rsp_valid_o) else $error("stale rsp");  // R2

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_layer_o))) else $error("rsp moved");  // R5

  AST_STALL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o) else $error("ready in stall");  // R5

  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (req_src_i > req_dst_i)) |=>
      (rsp_layer_o >= $past(req_dst_i) && rsp_layer_o <= $past(req_src_i))) else $error("out of range");  // R3

  AST_FLAT_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (req_src_i <= req_dst_i)) |=> (rsp_layer_o == $past(req_dst_i))) else $error("flat not dst");  // R4

  AST_RNG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_i != '0) else $error("rng stuck");  // R6
endmodule

bind tls_layer_pick tls_layer_pick_chk #(.LAYER_W(LAYER_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_src_i   (req_src_i),
  .req_dst_i   (req_dst_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_layer_o (rsp_layer_o),
  .rnd_i       (rnd_q)
);

// File: tb/sim_tls_layer_pick.sv
module sim_tls_layer_pick;
  localparam int LW = 3;
  localparam int NL = 1 << LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LW-1:0] req_src = '0;
  logic [LW-1:0] req_dst = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [LW-1:0] rsp_layer;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tls_layer_pick #(.LAYER_W(LW)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_src_i   (req_src),
    .req_dst_i   (req_dst),
    .rsp_valid_o (rsp_valid),
    .rsp_ready_i (rsp_ready),
    .rsp_layer_o (rsp_layer)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // full-period stream: every nonzero generator state is used exactly once
  task automatic run_period(input int s, input int d);
    int cnt[NL];
    int exp[NL];
    int n, tot, got;
    n = s - d + 1;
    tot = n * (n + 1) / 2;
    for (int j = 0; j < NL; j++) begin cnt[j] = 0; exp[j] = 0; end
    for (int v = 1; v < 65536; v++) begin
      int r, acc;
      r = (v * tot) >> 16;
      acc = 0;
      for (int j = 0; j < n; j++) begin
        acc += n - j;
        if (acc > r) begin exp[j]++; break; end
      end
    end
    got = 0;
    @(negedge clk);
    req_src = LW'(s); req_dst = LW'(d); req_valid = 1'b1; rsp_ready = 1'b1;
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got++;
        if (rsp_layer >= LW'(d) && rsp_layer <= LW'(s)) cnt[int'(rsp_layer) - d]++;
        else chk(1'b0, "R3 stream range", int'(rsp_layer), d);
      end
    end
    req_valid = 1'b0;
    chk(got == 65535, "R2 stream count", got, 65535);
    for (int j = 0; j < n; j++)
      chk(cnt[j] == exp[j], "R6 layer count", cnt[j], exp[j]);
    for (int j = 0; j + 1 < n; j++)
      chk(cnt[j] > cnt[j+1], "R7 falling weight", cnt[j], cnt[j+1] + 1);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [LW-1:0] held;
    #1;
    chk(rsp_valid == 1'b0, "R1 valid in reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // every source/destination pair, one request each
    for (int s = 0; s < NL; s++) begin
      for (int d = 0; d < NL; d++) begin
        req_src = LW'(s); req_dst = LW'(d); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2 rsp one cycle", int'(rsp_valid), 1);
        if (s > d)
          chk(int'(rsp_layer) >= d && int'(rsp_layer) <= s, "R3 in range", int'(rsp_layer), d);
        else
          chk(int'(rsp_layer) == d, "R4 flat gives dst", int'(rsp_layer), d);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 rsp retired", int'(rsp_valid), 0);
      end
    end

    // stall with a queued request
    rsp_ready = 1'b0;
    req_src = 3'd5; req_dst = 3'd2; req_valid = 1'b1;
    @(negedge clk);
    req_src = 3'd3; req_dst = 3'd3;
    held = rsp_layer;
    chk(rsp_valid == 1'b1, "R5 stalled valid", int'(rsp_valid), 1);
    chk(int'(held) >= 2 && int'(held) <= 5, "R3 stalled range", int'(held), 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R5 held valid", int'(rsp_valid), 1);
      chk(rsp_layer == held, "R5 held layer", int'(rsp_layer), int'(held));
      chk(req_ready == 1'b0, "R5 ready low", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R5 queued taken", int'(rsp_valid), 1);
    chk(rsp_layer == 3'd3, "R4 queued flat", int'(rsp_layer), 3);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 drained", int'(rsp_valid), 0);

    run_period(4, 1);
    run_period(7, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule